// File: doc/BRIEF.md
# Maskable Interrupt Acknowledge Sequencer

This block is the processor-side control for one level-sensitive, maskable interrupt request line. Software can turn an enable flag on or off. When the flag is on and the line is high, the block accepts the request and clears the flag at once. It then waits until the instruction in progress reports completion through a one-cycle pulse.

After that, the block issues active-low acknowledge strobes to the requesting device. Each strobe returns one byte on the data bus. The first byte must be the CALL opcode. The next two bytes give the low half and then the high half of the branch target. The block saves the current program counter on a downward-growing stack in memory, high byte first. It then loads the target into the program counter and steps the stack pointer down by two.

If the first byte is not CALL, the block abandons the sequence and raises an error flag. This request line has the lowest priority of the processor's interrupt sources. Arbitration against the other sources happens outside the block.

Top module: `intack_sequencer`

## Requirements
- R1: After reset, the block is in this state: `ack_n`=1, `busy`=0, `ie`=0, `vec_err`=0, `mem_we`=0, `pc`=PC_RST (default 16'h0100) and `sp`=SP_RST (default 16'h2400).
- R2: A one-cycle `ie_set` pulse sets `ie`. A one-cycle `ie_clr` pulse clears it. While `ie`=0, a high `irq_req` is ignored: `busy` stays 0 and `ack_n` stays 1.
- R3: When the block is idle, and `ie`=1 and `irq_req`=1 at a clock edge, the request is accepted at that edge. From the next cycle, `busy`=1 and `ie`=0. Acceptance takes priority over an `ie_set` in the same cycle.
- R4: After acceptance, `ack_n` stays high until an `instr_done` pulse has been received. A pulse arriving on the edge of acceptance itself does not count.
- R5: A valid service issues exactly three acknowledge strobes. Each strobe is one cycle with `ack_n`=0, and each is followed by at least one cycle with `ack_n`=1. The bytes captured are the opcode, then the target low byte, then the target high byte.
- R6: A valid service writes the return address in two consecutive cycles. The first write puts PC[15:8] at SP-1. The second puts PC[7:0] at SP-2.
- R7: After a valid service, `pc` equals {high byte, low byte} and `sp` equals the old SP minus 2. Otherwise, `pc` and `sp` change at no time.
- R8: If the first byte is not 8'hCD, the sequence has only that one strobe and no memory write. `pc` and `sp` do not change, `busy` returns to 0 and `vec_err` becomes 1. `vec_err` is cleared when the next request is accepted.
- R9: While `busy`=1, no new request is accepted, even if `ie` is set again during the service and `irq_req` stays high. That request is accepted on the first edge after the block returns to idle.
- R10: When `ie_set` and `ie_clr` are high in the same cycle, the clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | 1 | Level-sensitive maskable interrupt request |
| ie_set | input | 1 | Software pulse that enables the request |
| ie_clr | input | 1 | Software pulse that disables the request |
| instr_done | input | 1 | Pulse marking completion of the current instruction |
| data_in | input | 8 | Byte returned by the device during a strobe |
| ack_n | output | 1 | Active-low interrupt acknowledge strobe |
| busy | output | 1 | A request is being serviced |
| ie | output | 1 | Current state of the enable flag |
| vec_err | output | 1 | The last fetched opcode was not CALL |
| pc | output | 16 | Program counter |
| sp | output | 16 | Stack pointer |
| mem_we | output | 1 | Stack write strobe |
| mem_addr | output | 16 | Stack write address |
| mem_wdata | output | 8 | Stack write data |

## Verification
The bench holds the request high while the flag is clear. A design that does not gate the request would strobe the device without permission. It also re-enables the flag in the middle of a service with the request still high. A design that does not lock out new requests while busy would interleave a second acknowledge sequence, or lose the queued request after returning to idle.

Push order and addresses are compared byte by byte. Swapped halves or an off-by-one stack offset would corrupt the return address. The bench also feeds a non-CALL opcode. A faulty design would go on fetching, write the stack or move the program counter. Finally, the bench pulses set and clear together. A design with the wrong priority would leave the flag on.

// File: rtl/intack_pkg.sv
package intack_pkg;
  typedef enum logic [3:0] {
    ST_IDLE    = 4'd0,
    ST_WAIT    = 4'd1,
    ST_ACK_OP  = 4'd2,
    ST_CHECK   = 4'd3,
    ST_ACK_LO  = 4'd4,
    ST_GAP     = 4'd5,
    ST_ACK_HI  = 4'd6,
    ST_PUSH_HI = 4'd7,
    ST_PUSH_LO = 4'd8
  } seq_state_e;
endpackage

// File: rtl/intack_enable.sv
module intack_enable (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  input  logic accept_i,
  output logic ie_o
);
  logic ie_q, ie_d, ie_en;

  always_comb begin
    ie_en = accept_i | clr_i | set_i;
    if (accept_i)   ie_d = 1'b0;
    else if (clr_i) ie_d = 1'b0;
    else            ie_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ie_q <= 1'b0;
    else if (ie_en) ie_q <= ie_d;
  end

  assign ie_o = ie_q;
endmodule

// File: rtl/intack_fsm.sv
module intack_fsm
  import intack_pkg::*;
#(
  parameter int                DW      = 8,
  parameter logic [DW-1:0]     CALL_OP = 8'hCD
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_ok_i,
  input  logic          instr_done_i,
  input  logic [DW-1:0] data_i,
  output logic          ack_n_o,
  output logic          busy_o,
  output logic          accept_o,
  output logic          cap_lo_o,
  output logic          cap_hi_o,
  output logic          push_hi_o,
  output logic          push_lo_o,
  output logic          err_o
);
  seq_state_e    state_q, state_d;
  logic [DW-1:0] op_q;
  logic          op_en;
  logic          err_q, err_d, err_en;
  logic          bad_op;

  always_comb begin
    state_d  = state_q;
    accept_o = 1'b0;
    bad_op   = 1'b0;
    unique case (state_q)
      ST_IDLE:    if (req_ok_i) begin
                    state_d  = ST_WAIT;
                    accept_o = 1'b1;
                  end
      ST_WAIT:    if (instr_done_i) state_d = ST_ACK_OP;
      ST_ACK_OP:  state_d = ST_CHECK;
      ST_CHECK:   if (op_q == CALL_OP) state_d = ST_ACK_LO;
                  else begin
                    state_d = ST_IDLE;
                    bad_op  = 1'b1;
                  end
      ST_ACK_LO:  state_d = ST_GAP;
      ST_GAP:     state_d = ST_ACK_HI;
      ST_ACK_HI:  state_d = ST_PUSH_HI;
      ST_PUSH_HI: state_d = ST_PUSH_LO;
      ST_PUSH_LO: state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    op_en  = (state_q == ST_ACK_OP);
    err_en = accept_o | bad_op;
    err_d  = bad_op;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     op_q <= '0;
    else if (op_en) op_q <= data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      err_q <= 1'b0;
    else if (err_en) err_q <= err_d;
  end

  assign ack_n_o   = !((state_q == ST_ACK_OP) || (state_q == ST_ACK_LO) ||
                       (state_q == ST_ACK_HI));
  assign busy_o    = (state_q != ST_IDLE);
  assign cap_lo_o  = (state_q == ST_ACK_LO);
  assign cap_hi_o  = (state_q == ST_ACK_HI);
  assign push_hi_o = (state_q == ST_PUSH_HI);
  assign push_lo_o = (state_q == ST_PUSH_LO);
  assign err_o     = err_q;
endmodule

// File: rtl/intack_stack.sv
module intack_stack #(
  parameter int             DW     = 8,
  parameter int             AW     = 2 * DW,
  parameter logic [AW-1:0]  PC_RST = 16'h0100,
  parameter logic [AW-1:0]  SP_RST = 16'h2400
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] data_i,
  input  logic          cap_lo_i,
  input  logic          cap_hi_i,
  input  logic          push_hi_i,
  input  logic          push_lo_i,
  output logic [AW-1:0] pc_o,
  output logic [AW-1:0] sp_o,
  output logic          we_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] wdata_o
);
  localparam logic [AW-1:0] ONE = AW'(1);
  localparam logic [AW-1:0] TWO = AW'(2);

  logic [AW-1:0] pc_q, sp_q, pc_d, sp_d;
  logic [DW-1:0] tgt_lo_q, tgt_hi_q;
  logic          jump_en;

  always_comb begin
    jump_en = push_lo_i;
    pc_d    = {tgt_hi_q, tgt_lo_q};
    sp_d    = sp_q - TWO;
    we_o    = push_hi_i | push_lo_i;
    addr_o  = push_hi_i ? (sp_q - ONE) : (sp_q - TWO);
    wdata_o = push_hi_i ? pc_q[AW-1:DW] : pc_q[DW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        tgt_lo_q <= '0;
    else if (cap_lo_i) tgt_lo_q <= data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        tgt_hi_q <= '0;
    else if (cap_hi_i) tgt_hi_q <= data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= PC_RST;
      sp_q <= SP_RST;
    end else if (jump_en) begin
      pc_q <= pc_d;
      sp_q <= sp_d;
    end
  end

  assign pc_o = pc_q;
  assign sp_o = sp_q;
endmodule

// File: rtl/intack_sequencer.sv
module intack_sequencer #(
  parameter int                  DW      = 8,
  parameter int                  AW      = 2 * DW,
  parameter logic [DW-1:0]       CALL_OP = 8'hCD,
  parameter logic [AW-1:0]       PC_RST  = 16'h0100,
  parameter logic [AW-1:0]       SP_RST  = 16'h2400
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          irq_req,
  input  logic          ie_set,
  input  logic          ie_clr,
  input  logic          instr_done,
  input  logic [DW-1:0] data_in,
  output logic          ack_n,
  output logic          busy,
  output logic          ie,
  output logic          vec_err,
  output logic [AW-1:0] pc,
  output logic [AW-1:0] sp,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata
);
  logic accept, cap_lo, cap_hi, push_hi, push_lo;

  intack_enable u_enable (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_i    (ie_set),
    .clr_i    (ie_clr),
    .accept_i (accept),
    .ie_o     (ie)
  );

  intack_fsm #(.DW(DW), .CALL_OP(CALL_OP)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_ok_i     (ie & irq_req),
    .instr_done_i (instr_done),
    .data_i       (data_in),
    .ack_n_o      (ack_n),
    .busy_o       (busy),
    .accept_o     (accept),
    .cap_lo_o     (cap_lo),
    .cap_hi_o     (cap_hi),
    .push_hi_o    (push_hi),
    .push_lo_o    (push_lo),
    .err_o        (vec_err)
  );

  intack_stack #(.DW(DW), .AW(AW), .PC_RST(PC_RST), .SP_RST(SP_RST)) u_stack (
    .clk       (clk),
    .rst_n     (rst_n),
    .data_i    (data_in),
    .cap_lo_i  (cap_lo),
    .cap_hi_i  (cap_hi),
    .push_hi_i (push_hi),
    .push_lo_i (push_lo),
    .pc_o      (pc),
    .sp_o      (sp),
    .we_o      (mem_we),
    .addr_o    (mem_addr),
    .wdata_o   (mem_wdata)
  );
endmodule

// File: rtl/intack_sequencer_chk.sv
module intack_sequencer_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          irq_req,
  input logic          instr_done,
  input logic          ack_n,
  input logic          busy,
  input logic          ie,
  input logic          vec_err,
  input logic [AW-1:0] pc,
  input logic [AW-1:0] sp,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr
);
  logic done_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  done_seen <= 1'b0;
    else if (!busy)              done_seen <= 1'b0;
    else if (instr_done)         done_seen <= 1'b1;
  end

  AST_IE_GATES_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(ie) && $past(irq_req)));                       // R2
  AST_IE_AUTO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !ie);                                                 // R3
  AST_ACK_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_n |-> done_seen);                                                // R4
  AST_STROBE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_n |=> ack_n);                                                    // R5
  AST_ACK_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_n |-> busy);                                                     // R9
  AST_PUSH_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && mem_addr == sp - AW'(1)) |=> (mem_we && mem_addr == sp - AW'(2))); // R6
  AST_SP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (sp != $past(sp)) |-> (sp == $past(sp) - AW'(2)));                    // R7
  AST_PC_AFTER_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (pc != $past(pc)) |-> $past(mem_we));                                 // R7
  AST_ERR_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vec_err) |-> (!busy && !mem_we && $stable(pc)));                // R8
endmodule

bind intack_sequencer intack_sequencer_chk #(.AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .irq_req    (irq_req),
  .instr_done (instr_done),
  .ack_n      (ack_n),
  .busy       (busy),
  .ie         (ie),
  .vec_err    (vec_err),
  .pc         (pc),
  .sp         (sp),
  .mem_we     (mem_we),
  .mem_addr   (mem_addr)
);

// File: tb/intack_sequencer_test.sv
`timescale 1ns/1ps
module intack_sequencer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        irq_req = 1'b0, ie_set = 1'b0, ie_clr = 1'b0, instr_done = 1'b0;
  logic [7:0]  data_in = 8'h00;
  logic        ack_n, busy, ie, vec_err, mem_we;
  logic [15:0] pc, sp, mem_addr;
  logic [7:0]  mem_wdata;

  int vectors = 0, miscompares = 0;
  int nstrobe, nwr, early, b2b;
  logic [15:0] wa[4];
  logic [7:0]  wd[4];
  logic [15:0] exp_pc, exp_sp;
  bit hold_irq = 0, set_mid = 0, finished = 0;

  always #2.5 clk = ~clk;

  intack_sequencer uut (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .ie_set(ie_set), .ie_clr(ie_clr),
    .instr_done(instr_done), .data_in(data_in), .ack_n(ack_n), .busy(busy), .ie(ie),
    .vec_err(vec_err), .pc(pc), .sp(sp), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic pulse_ie(input logic s, input logic c);
    @(negedge clk); ie_set = s; ie_clr = c;
    @(negedge clk); ie_set = 0; ie_clr = 0;
  endtask

  task automatic service(input logic [7:0] b0, input logic [7:0] b1,
                         input logic [7:0] b2, input int dly);
    logic prev_ack = 1'b1;
    bit seen_busy = 0;
    nstrobe = 0; nwr = 0; early = 0; b2b = 0;
    @(negedge clk); irq_req = 1'b1;
    for (int c = 0; c < 60; c++) begin
      @(negedge clk);
      instr_done = (c == dly);
      ie_set = (set_mid && c == 1);
      if (busy) seen_busy = 1;
      if (!ack_n) begin
        if (c <= dly) early = 1;
        if (!prev_ack) b2b = 1;
        data_in = (nstrobe == 0) ? b0 : (nstrobe == 1) ? b1 : b2;
        nstrobe++;
        if (!hold_irq) irq_req = 1'b0;
      end
      prev_ack = ack_n;
      if (mem_we && nwr < 4) begin wa[nwr] = mem_addr; wd[nwr] = mem_wdata; nwr++; end
      if (seen_busy && !busy) break;
    end
    instr_done = 0; ie_set = 0;
  endtask

  task automatic check_call(input logic [7:0] lo, input logic [7:0] hi);
    chk(nstrobe == 3, "R5 strobe count", nstrobe, 3);
    chk(b2b == 0, "R5 strobe gap", b2b, 0);
    chk(early == 0, "R4 ack before done", early, 0);
    chk(nwr == 2, "R6 write count", nwr, 2);
    chk(wa[0] == exp_sp - 16'd1 && wd[0] == exp_pc[15:8], "R6 high push",
        {wa[0], wd[0]}, {exp_sp - 16'd1, exp_pc[15:8]});
    chk(wa[1] == exp_sp - 16'd2 && wd[1] == exp_pc[7:0], "R6 low push",
        {wa[1], wd[1]}, {exp_sp - 16'd2, exp_pc[7:0]});
    exp_pc = {hi, lo}; exp_sp = exp_sp - 16'd2;
    chk(pc == exp_pc, "R7 pc", pc, exp_pc);
    chk(sp == exp_sp, "R7 sp", sp, exp_sp);
    chk(vec_err == 0, "R8 err clear on good call", vec_err, 0);
  endtask

  task automatic t_reset;
    chk(ack_n == 1 && busy == 0 && ie == 0 && vec_err == 0 && mem_we == 0, "R1 ctrl",
        {ack_n, busy, ie, vec_err, mem_we}, 5'b10000);
    chk(pc == 16'h0100, "R1 pc", pc, 16'h0100);
    chk(sp == 16'h2400, "R1 sp", sp, 16'h2400);
    exp_pc = 16'h0100; exp_sp = 16'h2400;
  endtask

  task automatic t_masked;
    int acks = 0, bz = 0;
    @(negedge clk); irq_req = 1'b1;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); instr_done = (i == 3);
      if (!ack_n) acks++;
      if (busy) bz++;
    end
    instr_done = 0; irq_req = 0;
    chk(acks == 0 && bz == 0, "R2 masked request ignored", {acks, bz}, 0);
  endtask

  task automatic t_basic;
    pulse_ie(1, 0);
    chk(ie == 1, "R2 ie set", ie, 1);
    service(8'hCD, 8'h34, 8'h12, 3);
    chk(ie == 0, "R3 ie cleared on accept", ie, 0);
    check_call(8'h34, 8'h12);
  endtask

  task automatic t_busy_lockout;
    pulse_ie(1, 0);
    hold_irq = 1; set_mid = 1;
    service(8'hCD, 8'h78, 8'h56, 4);
    hold_irq = 0; set_mid = 0;
    check_call(8'h78, 8'h56);
    chk(ie == 1, "R9 ie set during busy kept", ie, 1);
    @(negedge clk);
    chk(busy == 1 && ie == 0, "R9 queued request taken after idle", {busy, ie}, 2'b10);
    service(8'hCD, 8'hBC, 8'h9A, 2);
    check_call(8'hBC, 8'h9A);
  endtask

  task automatic t_bad_op;
    pulse_ie(1, 0);
    service(8'h3E, 8'h11, 8'h22, 2);
    chk(nstrobe == 1, "R8 single strobe", nstrobe, 1);
    chk(nwr == 0, "R8 no write", nwr, 0);
    chk(vec_err == 1, "R8 err raised", vec_err, 1);
    chk(pc == exp_pc && sp == exp_sp, "R8 pc/sp unchanged", {pc, sp}, {exp_pc, exp_sp});
    chk(busy == 0, "R8 back to idle", busy, 0);
    pulse_ie(1, 0);
    service(8'hCD, 8'h00, 8'h40, 5);
    check_call(8'h00, 8'h40);
  endtask

  task automatic t_set_clr;
    pulse_ie(1, 1);
    chk(ie == 0, "R10 clear wins", ie, 0);
    pulse_ie(1, 0);
    pulse_ie(0, 1);
    chk(ie == 0, "R2 ie clear", ie, 0);
  endtask

  initial begin
    for (int i = 0; i < 20000; i++) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_masked;
    t_basic;
    t_busy_lockout;
    t_bad_op;
    t_set_clr;
    repeat (3) @(negedge clk);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule